// File: doc/BRIEF.md
# UART Receive Queue with Level Trigger and Idle Timeout

This block holds characters that a UART receiver has already deserialised until software or a DMA engine drains them. Each stored entry carries the data byte together with a framing-error flag and a break flag, so error status stays attached to the byte it belongs to as the entry moves through the queue. The reader sees the oldest entry at the head outputs and removes it with a pop strobe.

Two service conditions tell the reader when to act. The level trigger is raised while occupancy is at or above a threshold chosen by a 3-bit code. The idle timeout is raised when data is waiting and no character has arrived for a programmed number of character times, measured by a tick from the baud logic. This lets a reader collect the last few bytes of a message that never reached the trigger level. A character that arrives when every slot is taken sets a sticky overrun flag and is dropped.

Top module: `uart_rxq`

## Requirements
- R1: The queue holds up to 64 entries in arrival order. `count` gives the occupancy, `empty` is high exactly when `count` is 0, and `head_data`, `head_ferr` and `head_brk` show the byte, framing-error flag and break flag of the oldest entry.
- R2: After a synchronous reset, `count` is 0, `empty` is 1, and `trig`, `tmo` and `ovr` are 0.
- R3: `trig` is high while `count` is at or above the level picked by `trig_sel`. The codes are: 0 → 1, 1 → 4, 2 → 8, 3 → 16, 4 → 32, and 5, 6 or 7 → 48.
- R4: `tmo_sel` picks the idle limit in character times: 0 → never, 1 → 4, 2 → 8, 3 → 16. With the queue non-empty, `tmo` rises once that many `char_tick` pulses have been seen since the last reset of the idle count. It then stays high until that count is reset again.
- R5: The idle count is reset by every `rx_valid` pulse and by every pop that removes an entry. It is held at zero while the queue is empty, and `tmo` is never high while the queue is empty.
- R6: If `rx_valid` arrives while `count` is 64, the character is discarded, the stored entries and head are unchanged, and `ovr` goes high. `ovr` stays high until `ovr_clr` is pulsed. If a new overrun and `ovr_clr` occur in the same cycle, the overrun wins.
- R7: A pop while the queue is empty has no effect.
- R8: A push and a pop that both take effect in the same cycle leave `count` unchanged.
- R9: Every result appears in the clock cycle after the edge that sampled the stimulus. The exception is `trig`, which follows `trig_sel` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | One-cycle strobe: a character has been received |
| rx_data | input | 8 | Received byte |
| rx_ferr | input | 1 | Framing error flag of the received byte |
| rx_brk | input | 1 | Break flag of the received byte |
| char_tick | input | 1 | One pulse per character time |
| pop | input | 1 | Remove the head entry |
| trig_sel | input | 3 | Trigger level code |
| tmo_sel | input | 2 | Idle timeout code |
| ovr_clr | input | 1 | Clear the sticky overrun flag |
| head_data | output | 8 | Byte of the oldest entry |
| head_ferr | output | 1 | Framing error flag of the oldest entry |
| head_brk | output | 1 | Break flag of the oldest entry |
| count | output | 7 | Number of stored entries |
| empty | output | 1 | Queue holds no entry |
| trig | output | 1 | Occupancy at or above trigger level |
| tmo | output | 1 | Idle timeout condition |
| ovr | output | 1 | Sticky overrun flag |

## Verification
Pushes, pops, overruns and tick pulses are all registered once. Their effect on `count`, the head fields, `ovr` and `tmo` is therefore due one cycle later. The bench drives each stimulus for exactly one clock period and samples one nanosecond after the capturing edge. `trig` depends combinationally on `trig_sel` and the registered count. The bench sweeps all eight codes at every occupancy from 0 to 64, re-sampling after a short settle delay without a clock edge in between. Idle timeouts are checked tick by tick, so the cycle in which `tmo` rises is pinned exactly for each limit.

// File: rtl/uart_rxq_pkg.sv
package uart_rxq_pkg;

    typedef struct packed {
        logic       brk;
        logic       ferr;
        logic [7:0] data;
    } rxq_ent_t;

    typedef enum logic [1:0] {
        TMO_OFF = 2'd0,
        TMO_4   = 2'd1,
        TMO_8   = 2'd2,
        TMO_16  = 2'd3
    } tmo_code_e;

    localparam int unsigned TMO_CNT_W = 5;

    // occupancy threshold for a trigger code
    function automatic int unsigned trig_level(input logic [2:0] code);
        case (code)
            3'd0:    return 1;
            3'd1:    return 4;
            3'd2:    return 8;
            3'd3:    return 16;
            3'd4:    return 32;
            default: return 48;
        endcase
    endfunction

    // idle limit in character times; 0 means disabled
    function automatic int unsigned tmo_limit(input tmo_code_e code);
        case (code)
            TMO_4:   return 4;
            TMO_8:   return 8;
            TMO_16:  return 16;
            default: return 0;
        endcase
    endfunction

endpackage

// File: rtl/uart_rxq_store.sv
module uart_rxq_store
    import uart_rxq_pkg::*;
#(
    parameter int unsigned DEPTH = 64
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           push,
    input  rxq_ent_t                       wr_ent,
    input  logic                           pop,
    output rxq_ent_t                       head,
    output logic [$clog2(DEPTH+1)-1:0]     count,
    output logic                           full,
    output logic                           popped
);
    localparam int unsigned PTR_W = $clog2(DEPTH);
    localparam int unsigned CNT_W = $clog2(DEPTH+1);

    rxq_ent_t             mem [DEPTH];
    logic [PTR_W-1:0]     wr_ptr;
    logic [PTR_W-1:0]     rd_ptr;
    logic [CNT_W-1:0]     cnt_q;
    logic                 do_push;
    logic                 do_pop;

    assign full    = (cnt_q == CNT_W'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && (cnt_q != '0);
    assign popped  = do_pop;
    assign head    = mem[rd_ptr];
    assign count   = cnt_q;

    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH-1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr] <= wr_ent;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt_q  <= '0;
        end else begin
            if (do_push) begin
                wr_ptr <= ptr_next(wr_ptr);
            end
            if (do_pop) begin
                rd_ptr <= ptr_next(rd_ptr);
            end
            case ({do_push, do_pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

endmodule

// File: rtl/uart_rxq_timer.sv
module uart_rxq_timer
    import uart_rxq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      restart,
    input  logic      tick,
    input  logic      nonempty,
    input  tmo_code_e sel,
    output logic      expired
);
    logic [TMO_CNT_W-1:0] idle_q;
    logic [TMO_CNT_W-1:0] limit;

    assign limit = TMO_CNT_W'(tmo_limit(sel));

    always_ff @(posedge clk) begin
        if (rst || restart || !nonempty) begin
            idle_q <= '0;
        end else if (tick && (idle_q < limit)) begin
            idle_q <= idle_q + 1'b1;
        end
    end

    assign expired = (sel != TMO_OFF) && nonempty && (idle_q >= limit);

endmodule

// File: rtl/uart_rxq.sv
module uart_rxq
    import uart_rxq_pkg::*;
#(
    parameter int unsigned DEPTH = 64
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       rx_valid,
    input  logic [7:0]                 rx_data,
    input  logic                       rx_ferr,
    input  logic                       rx_brk,
    input  logic                       char_tick,
    input  logic                       pop,
    input  logic [2:0]                 trig_sel,
    input  logic [1:0]                 tmo_sel,
    input  logic                       ovr_clr,
    output logic [7:0]                 head_data,
    output logic                       head_ferr,
    output logic                       head_brk,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic                       empty,
    output logic                       trig,
    output logic                       tmo,
    output logic                       ovr
);
    localparam int unsigned CNT_W = $clog2(DEPTH+1);

    rxq_ent_t         wr_ent;
    rxq_ent_t         head;
    logic [CNT_W-1:0] cnt;
    logic             full;
    logic             popped;
    logic             ovr_q;

    assign wr_ent = '{brk: rx_brk, ferr: rx_ferr, data: rx_data};

    uart_rxq_store #(.DEPTH(DEPTH)) u_store (
        .clk    (clk),
        .rst    (rst),
        .push   (rx_valid),
        .wr_ent (wr_ent),
        .pop    (pop),
        .head   (head),
        .count  (cnt),
        .full   (full),
        .popped (popped)
    );

    uart_rxq_timer u_timer (
        .clk      (clk),
        .rst      (rst),
        .restart  (rx_valid || popped),
        .tick     (char_tick),
        .nonempty (cnt != '0),
        .sel      (tmo_code_e'(tmo_sel)),
        .expired  (tmo)
    );

    // sticky overrun: a new event outranks a clear in the same cycle
    always_ff @(posedge clk) begin
        if (rst) begin
            ovr_q <= 1'b0;
        end else if (rx_valid && full) begin
            ovr_q <= 1'b1;
        end else if (ovr_clr) begin
            ovr_q <= 1'b0;
        end
    end

    assign trig      = (cnt >= CNT_W'(trig_level(trig_sel)));
    assign count     = cnt;
    assign empty     = (cnt == '0);
    assign ovr       = ovr_q;
    assign head_data = head.data;
    assign head_ferr = head.ferr;
    assign head_brk  = head.brk;

endmodule

// File: rtl/uart_rxq_chk.sv
module uart_rxq_chk #(
    parameter int unsigned DEPTH = 64
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       rx_valid,
    input logic                       pop,
    input logic                       ovr_clr,
    input logic [1:0]                 tmo_sel,
    input logic [$clog2(DEPTH+1)-1:0] count,
    input logic [9:0]                 head,
    input logic                       tmo,
    input logic                       ovr
);
    localparam int unsigned CNT_W = $clog2(DEPTH+1);

    assert_count_bound_R1: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_W'(DEPTH));

    assert_tmo_needs_data_R5: assert property (@(posedge clk) disable iff (rst)
        tmo |-> (count != '0));

    assert_rx_restarts_idle_R5: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && count != CNT_W'(DEPTH)) |=> !tmo);

    assert_tmo_off_R4: assert property (@(posedge clk) disable iff (rst)
        (tmo_sel == 2'd0) |-> !tmo);

    assert_ovr_set_R6: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && count == CNT_W'(DEPTH)) |=> ovr);

    assert_ovr_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        (ovr && !ovr_clr) |=> ovr);

    assert_ovr_discard_R6: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && !pop && count == CNT_W'(DEPTH)) |=>
            (count == CNT_W'(DEPTH)) && $stable(head));

    assert_pop_empty_R7: assert property (@(posedge clk) disable iff (rst)
        (pop && !rx_valid && count == '0) |=> (count == '0));

    assert_push_pop_R8: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && pop && count != '0 && count != CNT_W'(DEPTH)) |=> $stable(count));

endmodule

bind uart_rxq uart_rxq_chk #(.DEPTH(DEPTH)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .rx_valid (rx_valid),
    .pop      (pop),
    .ovr_clr  (ovr_clr),
    .tmo_sel  (tmo_sel),
    .count    (count),
    .head     ({head_brk, head_ferr, head_data}),
    .tmo      (tmo),
    .ovr      (ovr)
);

// File: tb/uart_rxq_test.sv
`timescale 1ns/1ps
module uart_rxq_test;
    localparam int DEPTH = 64;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_data = '0;
    logic       rx_ferr = 1'b0;
    logic       rx_brk = 1'b0;
    logic       char_tick = 1'b0;
    logic       pop = 1'b0;
    logic [2:0] trig_sel = '0;
    logic [1:0] tmo_sel = '0;
    logic       ovr_clr = 1'b0;
    logic [7:0] head_data;
    logic       head_ferr;
    logic       head_brk;
    logic [6:0] count;
    logic       empty;
    logic       trig;
    logic       tmo;
    logic       ovr;

    int n_run = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    uart_rxq #(.DEPTH(DEPTH)) uut (
        .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_ferr(rx_ferr), .rx_brk(rx_brk), .char_tick(char_tick), .pop(pop),
        .trig_sel(trig_sel), .tmo_sel(tmo_sel), .ovr_clr(ovr_clr),
        .head_data(head_data), .head_ferr(head_ferr), .head_brk(head_brk),
        .count(count), .empty(empty), .trig(trig), .tmo(tmo), .ovr(ovr)
    );

    task automatic chk(input string what, input int got, input int exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", what, got, exp);
        end
    endtask

    function automatic int lvl(input int code);
        if (code == 0) return 1;
        if (code >= 5) return 48;
        return 4 << (code - 1);
    endfunction

    function automatic logic [9:0] pat(input int i);
        logic [7:0] d;
        d = 8'(i * 7 + 3);
        return {i[1], i[0], d};
    endfunction

    // one clock period of stimulus; returns 1 ns after the capturing edge
    task automatic cyc(input logic v, input logic [9:0] e, input logic tk,
                       input logic p, input logic clr);
        rx_valid = v; {rx_brk, rx_ferr, rx_data} = e;
        char_tick = tk; pop = p; ovr_clr = clr;
        @(posedge clk);
        #1;
        rx_valid = 0; char_tick = 0; pop = 0; ovr_clr = 0;
    endtask

    task automatic trig_sweep(input int n);
        for (int c = 0; c < 8; c++) begin
            trig_sel = 3'(c);
            #1;
            chk($sformatf("R3 trig code %0d count %0d", c, n), int'(trig), int'(n >= lvl(c)));
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : main
        repeat (3) @(posedge clk);
        #1 rst = 0;
        chk("R2 count", int'(count), 0);
        chk("R2 empty", int'(empty), 1);
        chk("R2 trig", int'(trig), 0);
        chk("R2 tmo", int'(tmo), 0);
        chk("R2 ovr", int'(ovr), 0);

        // fill to the top, sweeping trigger codes at every occupancy
        trig_sweep(0);
        for (int i = 0; i < DEPTH; i++) begin
            cyc(1, pat(i), 0, 0, 0);
            chk("R1 R9 count after push", int'(count), i + 1);
            chk("R1 empty flag", int'(empty), 0);
            trig_sweep(i + 1);
        end

        // overrun at full
        cyc(1, 10'h3EE, 0, 0, 0);
        chk("R6 ovr set", int'(ovr), 1);
        chk("R6 count held", int'(count), DEPTH);
        chk("R6 head unchanged", int'({head_brk, head_ferr, head_data}), int'(pat(0)));
        cyc(0, '0, 0, 0, 0);
        chk("R6 ovr sticky", int'(ovr), 1);
        cyc(1, 10'h155, 0, 0, 1);
        chk("R6 set wins over clear", int'(ovr), 1);
        cyc(0, '0, 0, 0, 1);
        chk("R6 ovr cleared", int'(ovr), 0);

        // drain in order
        for (int i = 0; i < DEPTH; i++) begin
            chk($sformatf("R1 head entry %0d", i),
                int'({head_brk, head_ferr, head_data}), int'(pat(i)));
            cyc(0, '0, 0, 1, 0);
            chk("R1 count after pop", int'(count), DEPTH - 1 - i);
        end
        chk("R1 empty after drain", int'(empty), 1);

        // pop on empty
        cyc(0, '0, 0, 1, 0);
        chk("R7 count after empty pop", int'(count), 0);
        cyc(1, 10'h233, 0, 0, 0);
        chk("R7 head after empty pop", int'({head_brk, head_ferr, head_data}), 'h233);
        cyc(0, '0, 0, 1, 0);

        // simultaneous push and pop
        for (int i = 0; i < 3; i++) cyc(1, pat(100 + i), 0, 0, 0);
        cyc(1, pat(103), 0, 1, 0);
        chk("R8 count with push and pop", int'(count), 3);
        for (int i = 1; i < 4; i++) begin
            chk("R8 order after push and pop",
                int'({head_brk, head_ferr, head_data}), int'(pat(100 + i)));
            cyc(0, '0, 0, 1, 0);
        end
        chk("R8 drained", int'(count), 0);

        // idle timeout for every code
        for (int s = 0; s < 4; s++) begin
            int lim;
            lim = (s == 0) ? 0 : (2 << s);
            tmo_sel = 2'(s);
            for (int t = 0; t < 20; t++) cyc(0, '0, 1, 0, 0);
            chk("R5 no tmo while empty", int'(tmo), 0);
            cyc(1, pat(7), 0, 0, 0);
            for (int t = 1; t <= 20; t++) begin
                cyc(0, '0, 1, 0, 0);
                chk($sformatf("R4 tmo code %0d tick %0d", s, t), int'(tmo),
                    int'(s != 0 && t >= lim));
            end
            if (s != 0) begin
                cyc(1, pat(8), 0, 0, 0);
                chk("R5 rx restarts idle", int'(tmo), 0);
                for (int t = 1; t < lim; t++) cyc(0, '0, 1, 0, 0);
                chk("R5 one tick short", int'(tmo), 0);
                cyc(0, '0, 1, 0, 0);
                chk("R4 tmo at limit after restart", int'(tmo), 1);
                cyc(0, '0, 0, 1, 0);
                chk("R5 pop restarts idle", int'(tmo), 0);
                for (int t = 1; t < lim; t++) cyc(0, '0, 1, 0, 0);
                chk("R5 one tick short after pop", int'(tmo), 0);
                cyc(0, '0, 1, 0, 0);
                chk("R4 tmo after pop restart", int'(tmo), 1);
            end
            while (count != 0) cyc(0, '0, 0, 1, 0);
            chk("R5 tmo low once empty", int'(tmo), 0);
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule